// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C master. A sequencer above it issues single bus operations, one at a time: a bus-recovery burst, a START condition, a STOP condition, a byte write with acknowledge check, or a byte read that ends with an acknowledge or not-acknowledge chosen by the sequencer. The engine turns each operation into a fixed sequence of changes on the clock and data lines. It then reports completion with a one-cycle pulse that carries the received byte and the acknowledge level seen on the bus.

Both lines are open-drain. The engine only asserts a drive-low enable for each line, and a released line is pulled high outside the block. All line timing is counted in delay units. One delay unit lasts a parameterised number of system clocks, and every data bit takes four units on writes. Each operation is a fixed list of units. The engine changes a line only at the start of a unit and samples the data line only at the end of one. The address bytes, repeated starts and transaction framing are left to the sequencer. Arbitration between masters, clock stretching by slaves and ten-bit addressing are not handled.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both drive-low enables are off (lines released), `cmd_ready` is high and `done` is low.
- R2: An operation is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the edge that raises `done`. A `cmd_valid` pulse while busy has no effect on the lines or on the result.
- R3: The lines change only on the accepting edge and then every `DIV` clocks at a unit boundary. `done` is high for exactly one cycle, starting at the edge that ends the last unit, and `cmd_ready` returns high at that same edge.
- R4: Operation code 0 (recover) releases data and gives nine clock pulses. Each pulse is two units with the clock driven low, then two units with it released. The data line stays released throughout the pulses. A STOP sequence follows, for 40 units in all.
- R5: Operation code 1 (START) takes three units: release data, release clock, drive data low. Data therefore falls while the clock is high.
- R6: Operation code 2 (STOP) takes four units: drive clock low, drive data low, release clock, release data. Data therefore rises while the clock is high.
- R7: Operation code 3 (write) sends `cmd_byte` most significant bit first. Each bit takes four units: clock low, data set, then two units with the clock released. Data changes only while the clock is driven low.
- R8: After the eighth written bit come five acknowledge units: clock low, data released, clock released, hold, clock low. The bus data level is sampled at the end of the hold unit and appears on `ack_bit` (0 = acknowledged, 1 = not). The write takes 37 units.
- R9: Operation code 4 (read) releases data in its first unit. Each of its eight bits takes three units: clock low, clock released, hold. Data is sampled at the end of the clock-released unit and shifted into `rx_data` most significant bit first.
- R10: After the eighth read bit, the engine drives data to the `cmd_nack` level (0 = drive low for an acknowledge, 1 = released) over five units: clock low, data set, clock released, hold, clock low. `ack_bit` reports the bus level sampled at the end of the hold unit. The read takes 29 units.
- R11: Operation codes 5 to 7 complete after one unit and leave both lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Operation request |
| cmd_ready | output | 1 | Engine idle, request will be taken |
| cmd_op | input | 3 | Operation code (0 recover, 1 START, 2 STOP, 3 write, 4 read) |
| cmd_byte | input | 8 | Byte to send for a write |
| cmd_nack | input | 1 | Level driven in the read acknowledge slot (1 = not-acknowledge) |
| sda_in | input | 1 | Sensed level of the data line |
| scl_lo | output | 1 | Drive clock line low |
| sda_lo | output | 1 | Drive data line low |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Byte received by the last read |
| ack_bit | output | 1 | Data level sampled in the last acknowledge slot |

## Verification
The embedded assertions watch several rules on every cycle. Lines move only at unit boundaries. During writes and reads, data stays steady while the clock is high. START and STOP produce their data edges only while the clock is released. Data is released in the write-acknowledge slot and across the recovery pulses, and `done` lasts a single cycle. Other behaviour is shown only by the bench's scenarios, where a unit-by-unit reference waveform is compared on every clock. These cover the exact unit counts, the most-significant-first bit order on the lines, the bytes and acknowledge levels returned from a responding or silent slave, and a request made while busy being ignored.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int STEPW      = 6;
  localparam int BYTE_BITS  = 8;
  localparam int REC_PULSES = 9;
  localparam int ACK_UNITS  = 5;
  localparam int STOP_UNITS = 4;
  localparam int WR_BODY    = BYTE_BITS * 4;
  localparam int RD_BODY    = BYTE_BITS * 3;
  localparam int REC_BODY   = REC_PULSES * 4;

  localparam logic [2:0] OP_RECOVER = 3'd0;
  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_WRITE   = 3'd3;
  localparam logic [2:0] OP_READ    = 3'd4;

  typedef enum logic [1:0] {SCL_KEEP, SCL_LOW, SCL_REL} scl_act_e;
  typedef enum logic [2:0] {SDA_KEEP, SDA_REL, SDA_LOW, SDA_TX, SDA_ACKV} sda_act_e;
  typedef enum logic [1:0] {SMP_NONE, SMP_DATA, SMP_ACK} smp_e;

  typedef struct packed {
    scl_act_e   scl;
    sda_act_e   sda;
    smp_e       smp;
    logic [2:0] bsel;
    logic       last;
  } step_t;

  function automatic int unsigned op_units(logic [2:0] op);
    case (op)
      OP_RECOVER: return REC_BODY + STOP_UNITS;
      OP_START:   return 3;
      OP_STOP:    return STOP_UNITS;
      OP_WRITE:   return WR_BODY + ACK_UNITS;
      OP_READ:    return RD_BODY + ACK_UNITS;
      default:    return 1;
    endcase
  endfunction

  function automatic step_t stop_tail(int unsigned s);
    step_t t;
    t = '0;
    case (s)
      0:       t.scl = SCL_LOW;
      1:       t.sda = SDA_LOW;
      2:       t.scl = SCL_REL;
      default: t.sda = SDA_REL;
    endcase
    return t;
  endfunction

  function automatic step_t ack_tail(int unsigned a, logic master_drives);
    step_t t;
    t = '0;
    case (a)
      0:       t.scl = SCL_LOW;
      1:       t.sda = master_drives ? SDA_ACKV : SDA_REL;
      2:       t.scl = SCL_REL;
      3:       t.smp = SMP_ACK;
      default: t.scl = SCL_LOW;
    endcase
    return t;
  endfunction

  function automatic step_t decode_step(logic [2:0] op, logic [STEPW-1:0] idx);
    step_t t;
    int unsigned i;
    i = 32'(idx);
    t = '0;
    case (op)
      OP_RECOVER: begin
        if (i < REC_BODY) begin
          case (i % 4)
            0: begin
              t.scl = SCL_LOW;
              if (i == 0) t.sda = SDA_REL;
            end
            2:       t.scl = SCL_REL;
            default: ;
          endcase
        end else t = stop_tail(i - REC_BODY);
      end
      OP_START: begin
        case (i)
          0:       t.sda = SDA_REL;
          1:       t.scl = SCL_REL;
          default: t.sda = SDA_LOW;
        endcase
      end
      OP_STOP: t = stop_tail(i);
      OP_WRITE: begin
        if (i < WR_BODY) begin
          case (i % 4)
            0: t.scl = SCL_LOW;
            1: begin
              t.sda  = SDA_TX;
              t.bsel = 3'(BYTE_BITS - 1 - i / 4);
            end
            2:       t.scl = SCL_REL;
            default: ;
          endcase
        end else t = ack_tail(i - WR_BODY, 1'b0);
      end
      OP_READ: begin
        if (i < RD_BODY) begin
          case (i % 3)
            0: begin
              t.scl = SCL_LOW;
              if (i == 0) t.sda = SDA_REL;
            end
            1: begin
              t.scl = SCL_REL;
              t.smp = SMP_DATA;
            end
            default: ;
          endcase
        end else t = ack_tail(i - RD_BODY, 1'b1);
      end
      default: ;
    endcase
    t.last = ((i + 1) == op_units(op));
    return t;
  endfunction
endpackage

// File: rtl/i2cb_unit_timer.sv
module i2cb_unit_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic unit_end
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign unit_end = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_shift.sv
module i2cb_shift #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] sel,
  input  logic                 cap,
  input  logic                 cap_bit,
  output logic                 tx_bit,
  output logic [W-1:0]         rx
);
  logic [W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx   <= '0;
    end else begin
      if (load) tx_q <= din;
      if (cap)  rx   <= {rx[W-2:0], cap_bit};
    end
  end

  assign tx_bit = tx_q[sel];
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cb_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_nack,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       ack_bit
);
  logic             busy;
  logic [2:0]       op_q;
  logic             nack_q;
  logic [STEPW-1:0] step_q;
  logic             unit_end;
  logic             tx_bit;

  // named events
  logic  accept, step_adv, finish, apply_en, data_smp, ack_smp, in_stop_tail;
  step_t cur, act;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;
  assign cur       = decode_step(op_q, step_q);
  assign step_adv  = busy && unit_end && !cur.last;
  assign finish    = busy && unit_end && cur.last;
  assign apply_en  = accept || step_adv;
  assign act       = accept ? decode_step(cmd_op, '0)
                            : decode_step(op_q, STEPW'(step_q + 1'b1));
  assign data_smp  = busy && unit_end && (cur.smp == SMP_DATA);
  assign ack_smp   = busy && unit_end && (cur.smp == SMP_ACK);
  assign in_stop_tail = busy && ((op_q == OP_STOP) ||
                        ((op_q == OP_RECOVER) && (32'(step_q) >= REC_BODY)));

  i2cb_unit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(apply_en), .run(busy), .unit_end(unit_end)
  );

  i2cb_shift #(.W(BYTE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(cmd_byte), .sel(act.bsel),
    .cap(data_smp), .cap_bit(sda_in), .tx_bit(tx_bit), .rx(rx_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_q    <= '0;
      nack_q  <= 1'b0;
      step_q  <= '0;
      done    <= 1'b0;
      ack_bit <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        op_q   <= cmd_op;
        nack_q <= cmd_nack;
        step_q <= '0;
      end else if (step_adv) begin
        step_q <= STEPW'(step_q + 1'b1);
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (ack_smp) ack_bit <= sda_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else if (apply_en) begin
      case (act.scl)
        SCL_LOW: scl_lo <= 1'b1;
        SCL_REL: scl_lo <= 1'b0;
        default: ;
      endcase
      case (act.sda)
        SDA_REL:  sda_lo <= 1'b0;
        SDA_LOW:  sda_lo <= 1'b1;
        SDA_TX:   sda_lo <= !tx_bit;
        SDA_ACKV: sda_lo <= !nack_q;
        default:  ;
      endcase
    end
  end

  AST_UNIT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(apply_en) |-> ($stable(scl_lo) && $stable(sda_lo))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && $stable(op_q))); // R2
  AST_RECOVER_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RECOVER && 32'(step_q) < REC_BODY) |-> !sda_lo); // R4
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_START && $rose(sda_lo)) |-> !scl_lo); // R5
  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop_tail && $fell(sda_lo)) |-> !scl_lo); // R6
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_WRITE || op_q == OP_READ) && !scl_lo && $past(!scl_lo))
      |-> $stable(sda_lo)); // R7
  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_smp && op_q == OP_WRITE) |-> (!sda_lo && !scl_lo)); // R8
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    data_smp |-> (!sda_lo && !scl_lo)); // R9
  AST_MASTER_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_READ && (32'(step_q) == RD_BODY + 2 || 32'(step_q) == RD_BODY + 3))
      |-> (sda_lo == !nack_q)); // R10
endmodule

// File: tb/sim_i2c_bit_engine.sv
`timescale 1ns/1ps
module sim_i2c_bit_engine;
  localparam int T = 3;
  localparam logic [2:0] C_REC = 3'd0, C_STA = 3'd1, C_STO = 3'd2, C_WR = 3'd3, C_RD = 3'd4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_nack, slv_lo;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       cmd_ready, scl_lo, sda_lo, done, ack_bit;
  logic [7:0] rx_data;
  logic       sda_in;
  assign sda_in = !(sda_lo || slv_lo);

  i2c_bit_engine #(.DIV(T)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .sda_in(sda_in),
    .scl_lo(scl_lo), .sda_lo(sda_lo), .done(done), .rx_data(rx_data), .ack_bit(ack_bit)
  );

  int vectors = 0;
  int errors  = 0;
  logic m_scl, m_sda;
  logic [1:0] uq[$];
  bit sq[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(bit s);
    uq.push_back({m_scl, m_sda});
    sq.push_back(s);
  endtask

  task automatic stop_seq();
    m_scl = 1; push(0);
    m_sda = 1; push(0);
    m_scl = 0; push(0);
    m_sda = 0; push(0);
  endtask

  // reference waveform, one entry per delay unit (drive-low levels)
  task automatic build(logic [2:0] op, logic [7:0] b, bit nack, logic [7:0] sb, bit sack);
    uq.delete(); sq.delete();
    case (op)
      C_REC: begin
        for (int p = 0; p < 9; p++) begin
          m_scl = 1; if (p == 0) m_sda = 0; push(0); push(0);
          m_scl = 0; push(0); push(0);
        end
        stop_seq();
      end
      C_STA: begin
        m_sda = 0; push(0);
        m_scl = 0; push(0);
        m_sda = 1; push(0);
      end
      C_STO: stop_seq();
      C_WR: begin
        for (int k = 7; k >= 0; k--) begin
          m_scl = 1; push(0);
          m_sda = !b[k]; push(0);
          m_scl = 0; push(0); push(0);
        end
        m_scl = 1; push(0);
        m_sda = 0; push(sack);
        m_scl = 0; push(sack); push(sack);
        m_scl = 1; push(0);
      end
      C_RD: begin
        for (int k = 7; k >= 0; k--) begin
          m_scl = 1; if (k == 7) m_sda = 0; push(!sb[k]);
          m_scl = 0; push(!sb[k]); push(!sb[k]);
        end
        m_scl = 1; push(0);
        m_sda = !nack; push(0);
        m_scl = 0; push(0); push(0);
        m_scl = 1; push(0);
      end
      default: push(0);
    endcase
  endtask

  task automatic run(logic [2:0] op, logic [7:0] b, bit nack, logic [7:0] sb, bit sack,
                     bit poke, string req);
    int n;
    build(op, b, nack, sb, sack);
    n = uq.size();
    check(cmd_ready == 1'b1, "R2", "ready before request", int'(cmd_ready), 1);
    cmd_valid = 1; cmd_op = op; cmd_byte = b; cmd_nack = nack;
    for (int i = 0; i <= n * T; i++) begin
      int u;
      @(negedge clk);
      if (i == 0) cmd_valid = 0;
      if (poke && i == 4) begin
        cmd_valid = 1; cmd_op = C_STO; cmd_byte = 8'hFF; cmd_nack = 1;
      end
      if (poke && i == 5) cmd_valid = 0;
      u = (i < n * T) ? i / T : n - 1;
      slv_lo = (i < n * T) ? sq[u] : 1'b0;
      check(scl_lo == uq[u][1], req, "scl_lo", int'(scl_lo), int'(uq[u][1]));
      check(sda_lo == uq[u][0], req, "sda_lo", int'(sda_lo), int'(uq[u][0]));
      check(done == (i == n * T), "R3", "done", int'(done), int'(i == n * T));
      check(cmd_ready == (i == n * T), "R2", "cmd_ready", int'(cmd_ready), int'(i == n * T));
    end
    if (op == C_WR) check(ack_bit == !sack, "R8", "ack_bit", int'(ack_bit), int'(!sack));
    if (op == C_RD) begin
      check(rx_data == sb, "R9", "rx_data", int'(rx_data), int'(sb));
      check(ack_bit == nack, "R10", "ack_bit", int'(ack_bit), int'(nack));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: got busy expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_byte = 0; cmd_nack = 0; slv_lo = 0;
    m_scl = 0; m_sda = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(scl_lo == 1'b0, "R1", "reset scl_lo", int'(scl_lo), 0);
    check(sda_lo == 1'b0, "R1", "reset sda_lo", int'(sda_lo), 0);
    check(cmd_ready == 1'b1, "R1", "reset cmd_ready", int'(cmd_ready), 1);
    check(done == 1'b0, "R1", "reset done", int'(done), 0);
    run(C_REC, 8'h00, 0, 8'h00, 0, 0, "R4");
    run(C_STA, 8'h00, 0, 8'h00, 0, 0, "R5");
    run(C_WR,  8'hA5, 0, 8'h00, 1, 0, "R7");   // slave acknowledges, R8
    run(C_WR,  8'h3C, 0, 8'h00, 0, 0, "R7");   // silent slave, R8
    run(C_STA, 8'h00, 0, 8'h00, 0, 0, "R5");   // repeated start
    run(C_WR,  8'h81, 0, 8'h00, 1, 1, "R2");   // request while busy ignored
    run(C_RD,  8'h00, 0, 8'h5A, 0, 0, "R9");   // master ACK, R10
    run(C_RD,  8'h00, 1, 8'hC3, 0, 0, "R10");  // master NACK
    run(C_STO, 8'h00, 0, 8'h00, 0, 0, "R6");
    run(3'd6,  8'h00, 0, 8'h00, 0, 0, "R11");
    run(3'd7,  8'h00, 0, 8'h00, 0, 1, "R11");
    run(C_RD,  8'h00, 0, 8'hFF, 0, 0, "R9");
    run(C_STO, 8'h00, 0, 8'h00, 0, 0, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule